// File: doc/BRIEF.md
# Ping-Pong Piecewise-Linear Gamma LUT

This block applies a transfer curve to each of the three colour channels of a pixel stream. The curve is piecewise linear: the top bits of each channel value pick a segment, and the segment's stored start value (base) is added to its stored slope (delta) scaled by the position inside the segment. Two fixed curves are computed arithmetically, with no storage, and a bypass mode passes pixels through unchanged.

Curve storage is held twice, as bank A and bank B. While one bank drives the pixel path, software fills the other through a single data register. Each data write advances an internal word pointer, so a whole curve is loaded by setting the index once and streaming data words. Once the idle bank is full, one mode write moves the pixel path onto it. A status code shows which bank is live, and writes aimed at the live bank are dropped, so the curve in use is never disturbed partway through a frame.

Top module: `gamma_pwl_lut`

## Requirements
- R1: After reset, out_valid is 0, status reads 0 and the mode is bypass (code 0).
- R2: A pixel accepted with pix_valid high appears on pix_out with out_valid high exactly two clock cycles later. out_valid is low in every other cycle.
- R3: In mode 0, and for the unused mode codes 5 to 7, every output channel equals its input channel. Channel c sits in pix_in/pix_out bits [10c+9:10c], with red c=0, green c=1 and blue c=2.
- R4: Mode 1 outputs (x*x + 512) >> 10. Mode 2 outputs 1023 - (((1023-x)^2 + 512) >> 10).
- R5: A register write to address 0 sets the point pointer to wdata[3:0] and clears the word counter. Each write to address 1 stores one word, in the order red base, green base, blue base, red delta, green delta, blue delta. After the sixth word the point pointer advances by one.
- R6: Write-control register (address 2): bits [2:0] form a channel enable mask, with bit 0 red, bit 1 green and bit 2 blue. A data word whose channel bit is 0 leaves that entry unchanged, but the pointer still advances. Reset value of the mask is 7.
- R7: Bit 3 of the write-control register picks the target bank: 0 selects A and 1 selects B.
- R8: Mode 3 evaluates bank A and mode 4 evaluates bank B as base[s] + ((delta[s]*f + 32) >> 6). Here s = x[9:6] and f = x[5:0]. The mode register is address 3, bits [2:0].
- R9: status reads 9 while mode is 3, 10 while mode is 4, and 0 otherwise. It changes only in the cycle after a mode write.
- R10: A data write whose target bank is the live bank (A in mode 3, B in mode 4) changes no entry. The word pointer still advances.
- R11: An evaluated result above 1023 is clamped to 1023.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | 0 index, 1 data, 2 write control, 3 mode |
| reg_wdata | input | 10 | Register write data |
| status | output | 4 | Live bank code: 9 = A, 10 = B, 0 = none |
| pix_valid | input | 1 | Input pixel valid |
| pix_in | input | 30 | Input pixel, three 10-bit channels |
| out_valid | output | 1 | Output pixel valid |
| pix_out | output | 30 | Output pixel, three 10-bit channels |

## Verification
A wrong word pointer, mask or bank decision during loading has no visible effect until the loaded bank becomes live. After a mode switch, every input value whose segment holds a corrupted entry then shows a wrong output two cycles after it enters the block. For this reason each bank is swept across all 1024 input codes on all three channels after every switch. Bank A is swept again after a blocked load, which exposes any write that reached the live bank. A wrong status or mode register is visible at the status port in the cycle after the offending write.

// File: rtl/gamma_pwl_pkg.sv
package gamma_pwl_pkg;
  localparam int NCH = 3;

  localparam logic [1:0] ADDR_INDEX = 2'd0;
  localparam logic [1:0] ADDR_DATA  = 2'd1;
  localparam logic [1:0] ADDR_WCTL  = 2'd2;
  localparam logic [1:0] ADDR_MODE  = 2'd3;

  localparam logic [2:0] MODE_BYPASS   = 3'd0;
  localparam logic [2:0] MODE_SQUARE   = 3'd1;
  localparam logic [2:0] MODE_COSQUARE = 3'd2;
  localparam logic [2:0] MODE_BANK_A   = 3'd3;
  localparam logic [2:0] MODE_BANK_B   = 3'd4;

  localparam logic [3:0] STAT_NONE   = 4'd0;
  localparam logic [3:0] STAT_BANK_A = 4'd9;
  localparam logic [3:0] STAT_BANK_B = 4'd10;

  localparam logic [2:0] WORDS_PER_POINT = 3'd6;
endpackage

// File: rtl/gamma_pwl_ctrl.sv
module gamma_pwl_ctrl
  import gamma_pwl_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SEG_BITS = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [2:0]          mode_q,
  output logic [3:0]          status,
  output logic [1:0]          bank_we,
  output logic [NCH-1:0]      chan_we,
  output logic                is_delta,
  output logic [SEG_BITS-1:0] wr_pt,
  output logic [DATA_W-1:0]   wr_data
);
  localparam logic [2:0] LAST_WORD = WORDS_PER_POINT - 3'd1;

  logic [2:0]          word_q, word_d;
  logic [SEG_BITS-1:0] pt_q, pt_d;
  logic [NCH-1:0]      mask_q, mask_d;
  logic                sel_q, sel_d;
  logic [2:0]          mode_d;
  logic                wr_index, wr_data_s, wr_wctl, wr_mode;
  logic                live_a, live_b;
  logic [2:0]          chan;

  always_comb begin
    wr_index  = reg_wr && (reg_addr == ADDR_INDEX);
    wr_data_s = reg_wr && (reg_addr == ADDR_DATA);
    wr_wctl   = reg_wr && (reg_addr == ADDR_WCTL);
    wr_mode   = reg_wr && (reg_addr == ADDR_MODE);
  end

  // next-state for pointer, control and mode
  always_comb begin
    word_d = word_q;
    pt_d   = pt_q;
    mask_d = mask_q;
    sel_d  = sel_q;
    mode_d = mode_q;
    if (wr_index) begin
      pt_d   = reg_wdata[SEG_BITS-1:0];
      word_d = 3'd0;
    end else if (wr_data_s) begin
      if (word_q == LAST_WORD) begin
        word_d = 3'd0;
        pt_d   = pt_q + SEG_BITS'(1);
      end else begin
        word_d = word_q + 3'd1;
      end
    end
    if (wr_wctl) begin
      mask_d = reg_wdata[NCH-1:0];
      sel_d  = reg_wdata[3];
    end
    if (wr_mode) begin
      mode_d = reg_wdata[2:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= 3'd0;
      pt_q   <= '0;
      mask_q <= '1;
      sel_q  <= 1'b0;
      mode_q <= MODE_BYPASS;
    end else begin
      word_q <= word_d;
      pt_q   <= pt_d;
      mask_q <= mask_d;
      sel_q  <= sel_d;
      mode_q <= mode_d;
    end
  end

  // write strobes toward the banks
  always_comb begin
    live_a   = (mode_q == MODE_BANK_A);
    live_b   = (mode_q == MODE_BANK_B);
    is_delta = (word_q >= 3'd3);
    chan     = is_delta ? (word_q - 3'd3) : word_q;
    bank_we[0] = wr_data_s && !sel_q && !live_a;
    bank_we[1] = wr_data_s &&  sel_q && !live_b;
    for (int c = 0; c < NCH; c++) begin
      chan_we[c] = mask_q[c] && (chan == 3'(c));
    end
    wr_pt   = pt_q;
    wr_data = reg_wdata;
  end

  always_comb begin
    unique case (mode_q)
      MODE_BANK_A: status = STAT_BANK_A;
      MODE_BANK_B: status = STAT_BANK_B;
      default:     status = STAT_NONE;
    endcase
  end

  // R9
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_addr == ADDR_MODE) |=> $stable(status));

  // R9
  status_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_NONE) || (status == STAT_BANK_A) || (status == STAT_BANK_B));

  // R5
  word_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_DATA && word_q == LAST_WORD)
      |=> (word_q == 3'd0) && (pt_q == ($past(pt_q) + SEG_BITS'(1))));

  // R10
  live_bank_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (status == STAT_BANK_A) |-> !bank_we[0]);
endmodule

// File: rtl/gamma_pwl_bank.sv
module gamma_pwl_bank
  import gamma_pwl_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SEG_BITS = 4
) (
  input  logic                    clk,
  input  logic                    bank_en,
  input  logic [NCH-1:0]          chan_we,
  input  logic                    is_delta,
  input  logic [SEG_BITS-1:0]     wr_pt,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic [NCH*SEG_BITS-1:0] rd_seg,
  output logic [NCH*DATA_W-1:0]   rd_base,
  output logic [NCH*DATA_W-1:0]   rd_delta
);
  localparam int NPTS = 1 << SEG_BITS;

  for (genvar c = 0; c < NCH; c++) begin : g_chan
    logic [DATA_W-1:0] base_m  [NPTS];
    logic [DATA_W-1:0] delta_m [NPTS];
    logic              base_en, delta_en;

    always_comb begin
      base_en  = bank_en && chan_we[c] && !is_delta;
      delta_en = bank_en && chan_we[c] &&  is_delta;
    end

    always_ff @(posedge clk) begin
      if (base_en) begin
        base_m[wr_pt] <= wr_data;
      end
      if (delta_en) begin
        delta_m[wr_pt] <= wr_data;
      end
    end

    always_comb begin
      rd_base[c*DATA_W +: DATA_W]  = base_m[rd_seg[c*SEG_BITS +: SEG_BITS]];
      rd_delta[c*DATA_W +: DATA_W] = delta_m[rd_seg[c*SEG_BITS +: SEG_BITS]];
    end
  end
endmodule

// File: rtl/gamma_pwl_eval.sv
module gamma_pwl_eval
  import gamma_pwl_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SEG_BITS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_s1,
  input  logic              en_s2,
  input  logic [2:0]        mode_in,
  input  logic [DATA_W-1:0] x_in,
  input  logic [DATA_W-1:0] base_in,
  input  logic [DATA_W-1:0] delta_in,
  output logic [DATA_W-1:0] y_out
);
  localparam int FRAC_W = DATA_W - SEG_BITS;
  localparam int PROD_W = DATA_W + FRAC_W;
  localparam int SQ_W   = 2 * DATA_W;
  localparam int HALF_F = 1 << (FRAC_W - 1);
  localparam int HALF_W = 1 << (DATA_W - 1);
  localparam logic [DATA_W-1:0] MAXV = '1;

  logic [2:0]        mode_q;
  logic [DATA_W-1:0] x_q, base_q, delta_q, y_d;
  logic [FRAC_W-1:0] frac;
  logic [PROD_W-1:0] prod_r;
  logic [DATA_W:0]   sum;
  logic [DATA_W-1:0] pwl_v, sq_v, cosq_v, inv_x;
  logic [SQ_W-1:0]   sq_r, cosq_r;

  // stage 1: capture pixel, mode and segment entry
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_BYPASS;
      x_q     <= '0;
      base_q  <= '0;
      delta_q <= '0;
    end else if (en_s1) begin
      mode_q  <= mode_in;
      x_q     <= x_in;
      base_q  <= base_in;
      delta_q <= delta_in;
    end
  end

  always_comb begin
    frac   = x_q[FRAC_W-1:0];
    prod_r = PROD_W'(delta_q) * PROD_W'(frac) + PROD_W'(HALF_F);
    sum    = (DATA_W+1)'(base_q) + (DATA_W+1)'(prod_r >> FRAC_W);
    pwl_v  = sum[DATA_W] ? MAXV : sum[DATA_W-1:0];

    sq_r   = SQ_W'(x_q) * SQ_W'(x_q) + SQ_W'(HALF_W);
    sq_v   = sq_r[SQ_W-1:DATA_W];
    inv_x  = MAXV - x_q;
    cosq_r = SQ_W'(inv_x) * SQ_W'(inv_x) + SQ_W'(HALF_W);
    cosq_v = MAXV - cosq_r[SQ_W-1:DATA_W];

    unique case (mode_q)
      MODE_SQUARE:              y_d = sq_v;
      MODE_COSQUARE:            y_d = cosq_v;
      MODE_BANK_A, MODE_BANK_B: y_d = pwl_v;
      default:                  y_d = x_q;
    endcase
  end

  // stage 2: result register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      y_out <= '0;
    end else if (en_s2) begin
      y_out <= y_d;
    end
  end

  // R3
  bypass_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_s2 && (mode_q == MODE_BYPASS)) |=> (y_out == $past(x_q)));
endmodule

// File: rtl/gamma_pwl_lut.sv
module gamma_pwl_lut
  import gamma_pwl_pkg::*;
#(
  parameter int DATA_W   = 10,
  parameter int SEG_BITS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [1:0]            reg_addr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [3:0]            status,
  input  logic                  pix_valid,
  input  logic [NCH*DATA_W-1:0] pix_in,
  output logic                  out_valid,
  output logic [NCH*DATA_W-1:0] pix_out
);
  logic [1:0]                rst_sync_q;
  logic                      rst_n_i;
  logic [2:0]                mode_q;
  logic [1:0]                bank_we;
  logic [NCH-1:0]            chan_we;
  logic                      is_delta;
  logic [SEG_BITS-1:0]       wr_pt;
  logic [DATA_W-1:0]         wr_data;
  logic [NCH*SEG_BITS-1:0]   rd_seg;
  logic [NCH*DATA_W-1:0]     base_bk  [2];
  logic [NCH*DATA_W-1:0]     delta_bk [2];
  logic [NCH*DATA_W-1:0]     base_sel, delta_sel;
  logic                      vld_s1_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_i = rst_sync_q[1];

  gamma_pwl_ctrl #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n_i),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .mode_q    (mode_q),
    .status    (status),
    .bank_we   (bank_we),
    .chan_we   (chan_we),
    .is_delta  (is_delta),
    .wr_pt     (wr_pt),
    .wr_data   (wr_data)
  );

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      rd_seg[c*SEG_BITS +: SEG_BITS] = pix_in[c*DATA_W + DATA_W - 1 -: SEG_BITS];
    end
  end

  for (genvar b = 0; b < 2; b++) begin : g_bank
    gamma_pwl_bank #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_bank (
      .clk      (clk),
      .bank_en  (bank_we[b]),
      .chan_we  (chan_we),
      .is_delta (is_delta),
      .wr_pt    (wr_pt),
      .wr_data  (wr_data),
      .rd_seg   (rd_seg),
      .rd_base  (base_bk[b]),
      .rd_delta (delta_bk[b])
    );
  end

  always_comb begin
    base_sel  = (mode_q == MODE_BANK_B) ? base_bk[1]  : base_bk[0];
    delta_sel = (mode_q == MODE_BANK_B) ? delta_bk[1] : delta_bk[0];
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      vld_s1_q  <= 1'b0;
      out_valid <= 1'b0;
    end else begin
      vld_s1_q  <= pix_valid;
      out_valid <= vld_s1_q;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_eval
    gamma_pwl_eval #(.DATA_W(DATA_W), .SEG_BITS(SEG_BITS)) u_eval (
      .clk      (clk),
      .rst_n    (rst_n_i),
      .en_s1    (pix_valid),
      .en_s2    (vld_s1_q),
      .mode_in  (mode_q),
      .x_in     (pix_in[c*DATA_W +: DATA_W]),
      .base_in  (base_sel[c*DATA_W +: DATA_W]),
      .delta_in (delta_sel[c*DATA_W +: DATA_W]),
      .y_out    (pix_out[c*DATA_W +: DATA_W])
    );
  end

  // R2
  out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    pix_valid |-> ##2 out_valid);

  // R2
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (!rst_n_i)
    !pix_valid |-> ##2 !out_valid);
endmodule

// File: tb/gamma_pwl_lut_tb.sv
module gamma_pwl_lut_tb;
  localparam int W    = 10;
  localparam int NPTS = 16;
  localparam int MAXV = 1023;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          reg_wr;
  logic [1:0]    reg_addr;
  logic [W-1:0]  reg_wdata;
  logic [3:0]    status;
  logic          pix_valid;
  logic [3*W-1:0] pix_in;
  logic          out_valid;
  logic [3*W-1:0] pix_out;

  always #2 clk = ~clk;

  gamma_pwl_lut u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .status(status), .pix_valid(pix_valid),
    .pix_in(pix_in), .out_valid(out_valid), .pix_out(pix_out)
  );

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 0;

  // bench model of loaded banks and register state
  int sb [2][3][NPTS];
  int sd [2][3][NPTS];
  int m_pt = 0, m_word = 0, m_mask = 7, m_sel = 0, m_mode = 0;

  // expected pipeline
  bit e_v1 = 0, e_v2 = 0;
  int e_p1 [3];
  int e_p2 [3];
  string tag = "R3";

  function automatic int expch(int c, int x);
    int v, s, f, r, inv;
    case (m_mode)
      1: v = (x * x + 512) >> 10;
      2: begin inv = MAXV - x; v = MAXV - ((inv * inv + 512) >> 10); end
      3, 4: begin
        r = m_mode - 3;
        s = x >> 6;
        f = x & 63;
        v = sb[r][c][s] + ((sd[r][c][s] * f + 32) >> 6);
        if (v > MAXV) v = MAXV;
      end
      default: v = x;
    endcase
    return v;
  endfunction

  task automatic reg_write(input int a, input int d);
    int c;
    bit blocked;
    reg_wr    = 1'b1;
    reg_addr  = 2'(a);
    reg_wdata = W'(d);
    case (a)
      0: begin m_pt = d % NPTS; m_word = 0; end
      1: begin
        c = m_word % 3;
        blocked = m_sel ? (m_mode == 4) : (m_mode == 3);
        if (!blocked && m_mask[c]) begin
          if (m_word >= 3) sd[m_sel][c][m_pt] = d;
          else             sb[m_sel][c][m_pt] = d;
        end
        if (m_word == 5) begin m_word = 0; m_pt = (m_pt + 1) % NPTS; end
        else m_word++;
      end
      2: begin m_mask = d & 7; m_sel = (d >> 3) & 1; end
      default: m_mode = d & 7;
    endcase
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic step(input bit v, input int r, input int g, input int b);
    int px [3];
    px[0] = r; px[1] = g; px[2] = b;
    n_vec++;
    if (out_valid !== e_v2) begin
      n_bad++;
      $display("FAIL R2 out_valid got %0b exp %0b", out_valid, e_v2);
    end
    if (e_v2) begin
      for (int c = 0; c < 3; c++) begin
        n_vec++;
        if (int'(pix_out[c*W +: W]) != e_p2[c]) begin
          n_bad++;
          $display("FAIL %s ch%0d got %0d exp %0d", tag, c, pix_out[c*W +: W], e_p2[c]);
        end
      end
    end
    e_v2 = e_v1; e_p2 = e_p1;
    e_v1 = v;
    for (int c = 0; c < 3; c++) e_p1[c] = expch(c, px[c]);
    pix_valid = v;
    pix_in = {W'(b), W'(g), W'(r)};
    @(negedge clk);
  endtask

  task automatic sweep(input string t);
    tag = t;
    for (int x = 0; x < 1024; x++) begin
      step(1'b1, x, MAXV - x, (x * 7 + 100) % 1024);
      if (x % 97 == 5) step(1'b0, 0, 0, 0); // R2 gap in the stream
    end
    step(1'b0, 0, 0, 0);
    step(1'b0, 0, 0, 0);
    step(1'b0, 0, 0, 0);
  endtask

  task automatic chk_status(input int exp, input string t);
    n_vec++;
    if (int'(status) != exp) begin
      n_bad++;
      $display("FAIL %s status got %0d exp %0d", t, status, exp);
    end
  endtask

  // sel: bank, mask: channels, first/cnt: points, seed: value family
  task automatic load(input int sel, input int mask, input int first, input int cnt, input int seed);
    int p, val;
    reg_write(2, (sel << 3) | mask);
    reg_write(0, first);
    for (int i = 0; i < cnt; i++) begin
      p = (first + i) % NPTS;
      for (int k = 0; k < 6; k++) begin
        if (k < 3) begin
          val = (p * 61 + k * 17 + seed * 5) % 1024;
          if (p == NPTS - 1) val = 1000 - k; // R11 drives the top segment past full scale
        end else begin
          val = (p * 37 + k * 11 + seed * 23) % 256;
          if (p == NPTS - 1) val = 255;
        end
        reg_write(1, val);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    pix_valid = 1'b0; pix_in = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk_status(0, "R1");
    n_vec++;
    if (out_valid !== 1'b0) begin
      n_bad++; $display("FAIL R1 out_valid got %0b exp 0", out_valid);
    end
    sweep("R1 R3 reset bypass");
    reg_write(3, 5);
    sweep("R3 unused code");
    reg_write(3, 1);
    sweep("R4 square");
    reg_write(3, 2);
    sweep("R4 cosquare");
    chk_status(0, "R9");
    load(0, 7, 0, NPTS, 1);
    reg_write(3, 3);
    chk_status(9, "R9");
    sweep("R8 R11 bank A");
    load(1, 7, 0, NPTS, 2);
    chk_status(9, "R9 hold");
    load(0, 7, 0, NPTS, 3); // R10 aimed at live bank A
    load(1, 5, 5, 3, 4);    // R5 R6 partial reload of points 5..7
    reg_write(3, 4);
    chk_status(10, "R9");
    sweep("R5 R6 R7 R8 bank B");
    reg_write(3, 3);
    chk_status(9, "R9");
    sweep("R10 bank A untouched");
    reg_write(3, 0);
    chk_status(0, "R9");
    sweep("R3 bypass again");
    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule